// File: doc/BRIEF.md
# Output and Shared-Memory Threshold Grant Generator

This block decides, for each output port and each priority on that port, whether the attached adapter may send another packet. It keeps occupancy counts at two levels. Each output has one counter for all packets queued toward it, whatever their priority. One global counter covers every packet held in the shared buffer.

When a packet is stored, the global count and the counts of all its destination outputs rise in the same cycle. A packet with no destination bits set (a locally consumed packet) raises only the global count. When one copy leaves an output, that output's count falls. The global count falls only when the copy that leaves is the last one pending for that packet.

There are two banks of thresholds, each with one entry per priority. The output bank is shared by all outputs, and the global bank applies to the shared buffer. Software loads them through a single write port. A grant for an (output, priority) pair is asserted only while both the output's count and the global count are strictly below the matching thresholds. The grants are registered.

Top module: `fc_grant_gen`

## Requirements
- R1: While reset is held and after it is released, every counter is zero, every threshold holds its maximum value (all ones), and every bit of `grant` is 1.
- R2: In a cycle with `enq_valid` high, the global count rises by one, and so does the count of every output whose bit is set in `enq_dest_mask`. With an all-zero mask, only the global count rises.
- R3: A cycle with `deq_valid` high lowers the count of output `deq_port` by one. The global count falls by one only if `deq_last` is also high.
- R4: When an increment and a decrement hit the same counter in one cycle, that counter keeps its value.
- R5: Counters saturate. A count at all ones does not increment, and a count at zero does not decrement.
- R6: Grant bit (o, p) is 1 exactly when the count of output o is strictly less than output threshold p, and the global count is strictly less than global threshold p. Priority 0 is the highest.
- R7: `grant` is registered. A change to a counter or a threshold at clock edge k shows on `grant` after edge k+1.
- R8: A pulse of `cfg_we` writes `cfg_data` into threshold entry `cfg_prio` of the bank chosen by `cfg_bank` (0 selects the output bank, 1 the global bank). The other bank and the other entries are left unchanged.
- R9: Grant for output o and priority p sits at bit index o*NUM_PRIO + p of `grant`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | A packet is stored this cycle |
| enq_dest_mask | input | NUM_OUT | Destination outputs of the stored packet |
| deq_valid | input | 1 | One packet copy leaves an output this cycle |
| deq_port | input | clog2(NUM_OUT) | Output the copy leaves from |
| deq_last | input | 1 | The leaving copy is the last pending one of its packet |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_bank | input | 1 | 0 = output threshold bank, 1 = global threshold bank |
| cfg_prio | input | clog2(NUM_PRIO) | Priority entry to write |
| cfg_data | input | CNT_W | Threshold value to write |
| grant | output | NUM_OUT*NUM_PRIO | Registered transmit grants, bit o*NUM_PRIO+p |

## Verification
The bench targets counters that reach all ones under repeated all-output stores and are then drained. A design that wraps would raise grants that should be off. It also dequeues from empty outputs, where a counter that underflows would later drop grants that should be on. Other cases are a store and a dequeue on the same output in one cycle (a design that favours one side drifts its count), copies that leave without the last flag (a design that lowers the global count on every copy releases global grants too early), and thresholds equal to the count (a design with a non-strict compare grants one packet too many). Every cycle is compared against a model that places grants one edge after the change, so a grant that is one cycle early or late shows up as a mismatch.

// File: rtl/fc_pkg.sv
package fc_pkg;

    typedef enum logic {
        THR_BANK_OUT  = 1'b0,
        THR_BANK_GLOB = 1'b1
    } thr_bank_e;

endpackage

// File: rtl/fc_occ_counter.sv
module fc_occ_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } occ_state_t;

    occ_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc && !dec && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end else if (dec && !inc && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;

endmodule

// File: rtl/fc_thresh_bank.sv
module fc_thresh_bank #(
    parameter int NUM_PRIO   = 4,
    parameter int CNT_W      = 8,
    parameter int PRIO_IDX_W = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [PRIO_IDX_W-1:0]           wr_idx,
    input  logic [CNT_W-1:0]                wr_val,
    output logic [NUM_PRIO-1:0][CNT_W-1:0]  thr_q
);

    typedef struct packed {
        logic [NUM_PRIO-1:0][CNT_W-1:0] thr;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NUM_PRIO; p++) begin
            if (wr_en && (wr_idx == PRIO_IDX_W'(p))) begin
                st_d.thr[p] = wr_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign thr_q = st_q.thr;

endmodule

// File: rtl/fc_grant_array.sv
module fc_grant_array #(
    parameter int NUM_OUT  = 4,
    parameter int NUM_PRIO = 4,
    parameter int CNT_W    = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_OUT-1:0][CNT_W-1:0]   out_cnt,
    input  logic [CNT_W-1:0]                glob_cnt,
    input  logic [NUM_PRIO-1:0][CNT_W-1:0]  out_thr,
    input  logic [NUM_PRIO-1:0][CNT_W-1:0]  glob_thr,
    output logic [NUM_OUT*NUM_PRIO-1:0]     grant_q
);

    localparam int NUM_GRANT = NUM_OUT * NUM_PRIO;

    typedef struct packed {
        logic [NUM_GRANT-1:0] grant;
    } grant_state_t;

    grant_state_t st_d, st_q;
    logic [NUM_PRIO-1:0] glob_ok;

    always_comb begin
        for (int p = 0; p < NUM_PRIO; p++) begin
            glob_ok[p] = (glob_cnt < glob_thr[p]);
        end
    end

    always_comb begin
        st_d = st_q;
        for (int o = 0; o < NUM_OUT; o++) begin
            for (int p = 0; p < NUM_PRIO; p++) begin
                st_d.grant[o*NUM_PRIO + p] = glob_ok[p] && (out_cnt[o] < out_thr[p]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_q = st_q.grant;

endmodule

// File: rtl/fc_grant_gen.sv
module fc_grant_gen #(
    parameter int NUM_OUT  = 4,
    parameter int NUM_PRIO = 4,
    parameter int CNT_W    = 8,
    localparam int OUT_IDX_W  = (NUM_OUT  > 1) ? $clog2(NUM_OUT)  : 1,
    localparam int PRIO_IDX_W = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enq_valid,
    input  logic [NUM_OUT-1:0]           enq_dest_mask,
    input  logic                         deq_valid,
    input  logic [OUT_IDX_W-1:0]         deq_port,
    input  logic                         deq_last,
    input  logic                         cfg_we,
    input  logic                         cfg_bank,
    input  logic [PRIO_IDX_W-1:0]        cfg_prio,
    input  logic [CNT_W-1:0]             cfg_data,
    output logic [NUM_OUT*NUM_PRIO-1:0]  grant
);

    import fc_pkg::*;

    thr_bank_e                       bank_sel;
    logic                            out_thr_we;
    logic                            glob_thr_we;
    logic [NUM_OUT-1:0]              out_inc;
    logic [NUM_OUT-1:0]              out_dec;
    logic                            glob_inc;
    logic                            glob_dec;
    logic [NUM_OUT-1:0][CNT_W-1:0]   out_cnt;
    logic [CNT_W-1:0]                glob_cnt;
    logic [NUM_PRIO-1:0][CNT_W-1:0]  out_thr;
    logic [NUM_PRIO-1:0][CNT_W-1:0]  glob_thr;

    always_comb begin
        bank_sel    = thr_bank_e'(cfg_bank);
        out_thr_we  = cfg_we && (bank_sel == THR_BANK_OUT);
        glob_thr_we = cfg_we && (bank_sel == THR_BANK_GLOB);
        glob_inc    = enq_valid;
        glob_dec    = deq_valid && deq_last;
        for (int o = 0; o < NUM_OUT; o++) begin
            out_inc[o] = enq_valid && enq_dest_mask[o];
            out_dec[o] = deq_valid && (deq_port == OUT_IDX_W'(o));
        end
    end

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out_cnt
        fc_occ_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (out_inc[o]),
            .dec   (out_dec[o]),
            .cnt_q (out_cnt[o])
        );
    end

    fc_occ_counter #(.CNT_W(CNT_W)) u_glob_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (glob_inc),
        .dec   (glob_dec),
        .cnt_q (glob_cnt)
    );

    fc_thresh_bank #(
        .NUM_PRIO   (NUM_PRIO),
        .CNT_W      (CNT_W),
        .PRIO_IDX_W (PRIO_IDX_W)
    ) u_out_thr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (out_thr_we),
        .wr_idx (cfg_prio),
        .wr_val (cfg_data),
        .thr_q  (out_thr)
    );

    fc_thresh_bank #(
        .NUM_PRIO   (NUM_PRIO),
        .CNT_W      (CNT_W),
        .PRIO_IDX_W (PRIO_IDX_W)
    ) u_glob_thr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (glob_thr_we),
        .wr_idx (cfg_prio),
        .wr_val (cfg_data),
        .thr_q  (glob_thr)
    );

    fc_grant_array #(
        .NUM_OUT  (NUM_OUT),
        .NUM_PRIO (NUM_PRIO),
        .CNT_W    (CNT_W)
    ) u_grant (
        .clk      (clk),
        .rst_n    (rst_n),
        .out_cnt  (out_cnt),
        .glob_cnt (glob_cnt),
        .out_thr  (out_thr),
        .glob_thr (glob_thr),
        .grant_q  (grant)
    );

endmodule

// File: rtl/fc_grant_gen_chk.sv
module fc_grant_gen_chk #(
    parameter int NUM_OUT    = 4,
    parameter int NUM_PRIO   = 4,
    parameter int CNT_W      = 8,
    parameter int OUT_IDX_W  = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            enq_valid,
    input  logic [NUM_OUT-1:0]              enq_dest_mask,
    input  logic                            deq_valid,
    input  logic [OUT_IDX_W-1:0]            deq_port,
    input  logic                            deq_last,
    input  logic [NUM_OUT-1:0][CNT_W-1:0]   out_cnt,
    input  logic [CNT_W-1:0]                glob_cnt,
    input  logic [NUM_PRIO-1:0][CNT_W-1:0]  out_thr,
    input  logic [NUM_PRIO-1:0][CNT_W-1:0]  glob_thr,
    input  logic [NUM_OUT*NUM_PRIO-1:0]     grant
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        AST_OUT_STORE_INC: assert property (@(posedge clk) disable iff (!rst_n)
            (enq_valid && enq_dest_mask[o] && !(deq_valid && deq_port == OUT_IDX_W'(o))
             && out_cnt[o] != CNT_MAX)
            |=> out_cnt[o] == $past(out_cnt[o]) + CNT_W'(1)); // R2

        AST_OUT_LEAVE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
            (deq_valid && deq_port == OUT_IDX_W'(o) && !(enq_valid && enq_dest_mask[o])
             && out_cnt[o] != '0)
            |=> out_cnt[o] == $past(out_cnt[o]) - CNT_W'(1)); // R3

        AST_OUT_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (deq_valid && deq_port == OUT_IDX_W'(o) && enq_valid && enq_dest_mask[o])
            |=> $stable(out_cnt[o])); // R4

        AST_OUT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (out_cnt[o] == '0) |=> (out_cnt[o] != CNT_MAX)); // R5

        for (genvar p = 0; p < NUM_PRIO; p++) begin : g_prio
            AST_GRANT_RULE: assert property (@(posedge clk) disable iff (!rst_n)
                grant[o*NUM_PRIO + p] ==
                $past((out_cnt[o] < out_thr[p]) && (glob_cnt < glob_thr[p]))); // R6
        end
    end

    AST_GLOB_STORE_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && !(deq_valid && deq_last) && glob_cnt != CNT_MAX)
        |=> glob_cnt == $past(glob_cnt) + CNT_W'(1)); // R2

    AST_GLOB_NOT_LAST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!enq_valid && !(deq_valid && deq_last))
        |=> $stable(glob_cnt)); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_cnt == CNT_MAX) |=> (glob_cnt != '0)); // R5

    AST_GRANT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(grant)); // R7

endmodule

bind fc_grant_gen fc_grant_gen_chk #(
    .NUM_OUT   (NUM_OUT),
    .NUM_PRIO  (NUM_PRIO),
    .CNT_W     (CNT_W),
    .OUT_IDX_W (OUT_IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enq_valid     (enq_valid),
    .enq_dest_mask (enq_dest_mask),
    .deq_valid     (deq_valid),
    .deq_port      (deq_port),
    .deq_last      (deq_last),
    .out_cnt       (out_cnt),
    .glob_cnt      (glob_cnt),
    .out_thr       (out_thr),
    .glob_thr      (glob_thr),
    .grant         (grant)
);

// File: tb/fc_grant_gen_test.sv
module fc_grant_gen_test;

    localparam int NO  = 4;
    localparam int NP  = 4;
    localparam int CW  = 8;
    localparam int NG  = NO * NP;
    localparam int MAXV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enq_valid = 1'b0;
    logic [NO-1:0] enq_dest_mask = '0;
    logic          deq_valid = 1'b0;
    logic [1:0]    deq_port = '0;
    logic          deq_last = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_bank = 1'b0;
    logic [1:0]    cfg_prio = '0;
    logic [CW-1:0] cfg_data = '0;
    logic [NG-1:0] grant;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int m_out [NO];
    int m_glob;
    int m_othr [NP];
    int m_gthr [NP];
    logic [NG-1:0] exp_grant;

    always #5 clk = ~clk;

    fc_grant_gen uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .enq_valid     (enq_valid),
        .enq_dest_mask (enq_dest_mask),
        .deq_valid     (deq_valid),
        .deq_port      (deq_port),
        .deq_last      (deq_last),
        .cfg_we        (cfg_we),
        .cfg_bank      (cfg_bank),
        .cfg_prio      (cfg_prio),
        .cfg_data      (cfg_data),
        .grant         (grant)
    );

    function automatic logic [NG-1:0] model_grant();
        logic [NG-1:0] g;
        for (int o = 0; o < NO; o++)
            for (int p = 0; p < NP; p++)
                g[o*NP + p] = (m_out[o] < m_othr[p]) && (m_glob < m_gthr[p]);
        return g;
    endfunction

    function automatic int sat_step(int v, bit up, bit dn);
        if (up && !dn && v != MAXV) return v + 1;
        if (dn && !up && v != 0)    return v - 1;
        return v;
    endfunction

    task automatic model_reset();
        for (int o = 0; o < NO; o++) m_out[o] = 0;
        m_glob = 0;
        for (int p = 0; p < NP; p++) begin
            m_othr[p] = MAXV;
            m_gthr[p] = MAXV;
        end
        exp_grant = '1;
    endtask

    task automatic model_apply();
        for (int o = 0; o < NO; o++)
            m_out[o] = sat_step(m_out[o], enq_valid && enq_dest_mask[o],
                                deq_valid && (int'(deq_port) == o));
        m_glob = sat_step(m_glob, enq_valid, deq_valid && deq_last);
        if (cfg_we) begin
            if (cfg_bank) m_gthr[cfg_prio] = int'(cfg_data);
            else          m_othr[cfg_prio] = int'(cfg_data);
        end
    endtask

    task automatic check_grant(string tag);
        total++;
        if (grant !== exp_grant) begin
            bad++;
            $display("FAIL %s grant=%h expected=%h", tag, grant, exp_grant);
        end
    endtask

    task automatic idle();
        enq_valid = 1'b0; enq_dest_mask = '0;
        deq_valid = 1'b0; deq_port = '0; deq_last = 1'b0;
        cfg_we = 1'b0; cfg_bank = 1'b0; cfg_prio = '0; cfg_data = '0;
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        exp_grant = model_grant();
        model_apply();
        @(negedge clk);
        check_grant(tag);
        idle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle();
        model_reset();
        repeat (3) @(negedge clk);
        check_grant("R1");
        rst_n = 1'b1;
    endtask

    task automatic wr_thr(bit bank, int prio, int val, string tag);
        cfg_we = 1'b1; cfg_bank = bank; cfg_prio = 2'(prio); cfg_data = CW'(val);
        tick(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired grant=%h expected=%h", grant, exp_grant);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        model_reset();
        do_reset();
        // R1: all grants on after release
        repeat (3) tick("R1");

        // R8: output thresholds to 1, global untouched
        for (int p = 0; p < NP; p++) wr_thr(1'b0, p, 1, "R8");
        tick("R8");

        // R2 and R9: one packet to output 2 only
        enq_valid = 1'b1; enq_dest_mask = 4'b0100;
        tick("R2");
        tick("R9");
        tick("R7");

        // R2: empty mask raises the global count only
        enq_valid = 1'b1; enq_dest_mask = 4'b0000;
        tick("R2");
        wr_thr(1'b1, 1, 2, "R8");
        tick("R6");

        // R3: a non-last copy leaves output 2, global stays at 2
        deq_valid = 1'b1; deq_port = 2'd2; deq_last = 1'b0;
        tick("R3");
        tick("R3");
        wr_thr(1'b1, 0, 3, "R8");
        tick("R6");
        // R3: last copy lowers the global count
        deq_valid = 1'b1; deq_port = 2'd3; deq_last = 1'b1;
        tick("R3");
        tick("R3");

        // R4: store and leave on output 2 in the same cycle
        enq_valid = 1'b1; enq_dest_mask = 4'b0100;
        deq_valid = 1'b1; deq_port = 2'd2; deq_last = 1'b1;
        tick("R4");
        tick("R4");

        // R5: leave from an empty output, then a single store
        for (int i = 0; i < 3; i++) begin
            deq_valid = 1'b1; deq_port = 2'd1; deq_last = 1'b0;
            tick("R5");
        end
        enq_valid = 1'b1; enq_dest_mask = 4'b0010;
        tick("R5");
        tick("R5");

        // R5: saturate every counter at all ones, then drain
        do_reset();
        for (int i = 0; i < MAXV + 8; i++) begin
            enq_valid = 1'b1; enq_dest_mask = 4'b1111;
            tick("R5");
        end
        for (int i = 0; i < 3; i++) begin
            deq_valid = 1'b1; deq_port = 2'(i); deq_last = 1'b1;
            tick("R5");
        end
        tick("R5");

        // R6/R7: constrained random traffic and threshold writes
        do_reset();
        for (int p = 0; p < NP; p++) begin
            wr_thr(1'b0, p, 2 + p, "R8");
            wr_thr(1'b1, p, 4 + 2*p, "R8");
        end
        for (int i = 0; i < 4000; i++) begin
            enq_valid     = ($urandom % 100) < 30;
            enq_dest_mask = NO'($urandom);
            deq_valid     = ($urandom % 100) < 60;
            deq_port      = 2'($urandom);
            deq_last      = 1'($urandom);
            cfg_we        = ($urandom % 100) < 4;
            cfg_bank      = 1'($urandom);
            cfg_prio      = 2'($urandom);
            cfg_data      = (($urandom % 20) == 0) ? CW'(MAXV) : CW'($urandom % 12);
            tick((i % 2 == 0) ? "R6" : "R7");
        end
        tick("R6");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule